// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins an A bus to a B bus through a set of independent byte-wide sections. In each section every direction of transfer owns a storage register, and a capture strobe of its own loads that register from the pins on its source side. A select per direction decides whether the driven side shows live data from the opposite bus or the value held in that direction's register. Two enables decide which side drives. The A-to-B enable is active high and the B-to-A enable is active low. With these two enables a section can isolate both buses, pass data one way, or swap stored data both ways at the same time.

Bidirectional pins appear as separate input, output and output-enable vectors, so a pad ring or a tristate wrapper outside the block closes the loop. The register on a side samples that side's resolved pin value. That value is the external input when the side is released, and the block's own output when the side is driving. This lets a value driven onto one side be copied into the register on that same side.

Capture strobes are ordinary inputs sampled by the system clock. A register loads when its strobe is seen low in one cycle and high in the next.

Top module: `tcvr_dual`

## Requirements
- R1: While `rst` is high, every bit of `a_oe` and `b_oe` is 0. Both registers of every section are zero after reset, which shows as all-zero outputs when stored data is selected.
- R2: The B side of section s drives (`b_oe` bits [s*8+7:s*8] all 1) exactly when `oe_ab[s]` is 1. Otherwise those bits are 0.
- R3: The A side of section s drives (`a_oe` slice all 1) exactly when `oe_ba_n[s]` is 0. Otherwise the slice is 0. With `oe_ab[s]`=0 and `oe_ba_n[s]`=1 the section is isolated and neither side drives.
- R4: With `sel_ab[s]`=0 the B output slice equals the live A input slice. With `sel_ab[s]`=1 it equals the A-to-B register, whatever `a_in` does.
- R5: With `sel_ba[s]`=0 the A output slice equals the live B input slice. With `sel_ba[s]`=1 it equals the B-to-A register.
- R6: A register loads only at a clock edge where its strobe is sampled 1 and was sampled 0 at the previous edge. Holding the strobe high loads once. Loading works in every enable state, isolation included.
- R7: When a side drives, its register samples that side's own output, not its external input. This copies one value into both registers.
- R8: The live path always takes the opposite side's external input. With both sides driving live data, `b_out` follows `a_in` and `a_out` follows `b_in`.
- R9: With `oe_ab[s]`=1, `oe_ba_n[s]`=0 and both selects 1, stored A data drives B and stored B data drives A at the same time.
- R10: Sections are independent. Strobes, selects and enables of section s affect only bit slice s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset |
| cp_ab | input | NUM_SECT | A-to-B capture strobe, one per section |
| cp_ba | input | NUM_SECT | B-to-A capture strobe, one per section |
| sel_ab | input | NUM_SECT | B output source: 0 live A, 1 stored |
| sel_ba | input | NUM_SECT | A output source: 0 live B, 1 stored |
| oe_ab | input | NUM_SECT | B side drive enable, active high |
| oe_ba_n | input | NUM_SECT | A side drive enable, active low |
| a_in | input | NUM_SECT*SECT_W | A pin input values |
| b_in | input | NUM_SECT*SECT_W | B pin input values |
| a_out | output | NUM_SECT*SECT_W | A pin output values |
| a_oe | output | NUM_SECT*SECT_W | A pin output enables, per bit |
| b_out | output | NUM_SECT*SECT_W | B pin output values |
| b_oe | output | NUM_SECT*SECT_W | B pin output enables, per bit |

## Verification
The bench builds the block at its default parameters: two sections of eight bits each. This width is enough to place different bytes on the two halves and show that a strobe, select or enable in one section leaves the other slice alone. Two sections also allow simultaneous strobes on both directions and both sections. The stimulus then covers isolation with storage, one-way live transfer, both-way live and stored exchange, and the loopback copy from a driven side.

// File: rtl/tcvr_pkg.sv
`timescale 1ns/1ps
package tcvr_pkg;

  // Source picked for a driven side
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

endpackage

// File: rtl/tcvr_capture_reg.sv
`timescale 1ns/1ps
// Storage register loaded on a sampled low-to-high strobe transition
module tcvr_capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic strobe_q;
  logic load;

  assign load = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b1;   // a strobe already high at release is not an edge
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/tcvr_path_mux.sv
`timescale 1ns/1ps
module tcvr_path_mux
  import tcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  src_sel_e     sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (sel)
      SRC_STORED: y = stored;
      default:    y = live;
    endcase
  end

endmodule

// File: rtl/tcvr_section.sv
`timescale 1ns/1ps
module tcvr_section
  import tcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cp_ab,
  input  logic         cp_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);

  logic         drive_a, drive_b;
  logic [W-1:0] reg_ab, reg_ba;
  logic [W-1:0] a_pin, b_pin;

  assign drive_b = oe_ab & ~rst;
  assign drive_a = ~oe_ba_n & ~rst;

  // Live data comes from the opposite external input only: no loop
  tcvr_path_mux #(.W(W)) i_mux_b (
    .sel    (src_sel_e'(sel_ab)),
    .live   (a_in),
    .stored (reg_ab),
    .y      (b_out)
  );

  tcvr_path_mux #(.W(W)) i_mux_a (
    .sel    (src_sel_e'(sel_ba)),
    .live   (b_in),
    .stored (reg_ba),
    .y      (a_out)
  );

  // Resolved pin value seen by each register
  assign a_pin = drive_a ? a_out : a_in;
  assign b_pin = drive_b ? b_out : b_in;

  tcvr_capture_reg #(.W(W)) i_reg_ab (
    .clk    (clk),
    .rst    (rst),
    .strobe (cp_ab),
    .d      (a_pin),
    .q      (reg_ab)
  );

  tcvr_capture_reg #(.W(W)) i_reg_ba (
    .clk    (clk),
    .rst    (rst),
    .strobe (cp_ba),
    .d      (b_pin),
    .q      (reg_ba)
  );

  assign a_oe = {W{drive_a}};
  assign b_oe = {W{drive_b}};

endmodule

// File: rtl/tcvr_dual.sv
`timescale 1ns/1ps
module tcvr_dual #(
  parameter int SECT_W   = 8,
  parameter int NUM_SECT = 2,
  localparam int BUS_W   = SECT_W * NUM_SECT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SECT-1:0] cp_ab,
  input  logic [NUM_SECT-1:0] cp_ba,
  input  logic [NUM_SECT-1:0] sel_ab,
  input  logic [NUM_SECT-1:0] sel_ba,
  input  logic [NUM_SECT-1:0] oe_ab,
  input  logic [NUM_SECT-1:0] oe_ba_n,
  input  logic [BUS_W-1:0]    a_in,
  input  logic [BUS_W-1:0]    b_in,
  output logic [BUS_W-1:0]    a_out,
  output logic [BUS_W-1:0]    a_oe,
  output logic [BUS_W-1:0]    b_out,
  output logic [BUS_W-1:0]    b_oe
);

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    tcvr_section #(.W(SECT_W)) i_sect (
      .clk     (clk),
      .rst     (rst),
      .cp_ab   (cp_ab[s]),
      .cp_ba   (cp_ba[s]),
      .sel_ab  (sel_ab[s]),
      .sel_ba  (sel_ba[s]),
      .oe_ab   (oe_ab[s]),
      .oe_ba_n (oe_ba_n[s]),
      .a_in    (a_in[s*SECT_W +: SECT_W]),
      .b_in    (b_in[s*SECT_W +: SECT_W]),
      .a_out   (a_out[s*SECT_W +: SECT_W]),
      .a_oe    (a_oe[s*SECT_W +: SECT_W]),
      .b_out   (b_out[s*SECT_W +: SECT_W]),
      .b_oe    (b_oe[s*SECT_W +: SECT_W])
    );
  end

endmodule

// File: rtl/tcvr_dual_chk.sv
`timescale 1ns/1ps
module tcvr_dual_chk #(
  parameter int SECT_W   = 8,
  parameter int NUM_SECT = 2,
  localparam int BUS_W   = SECT_W * NUM_SECT
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_SECT-1:0] cp_ab,
  input logic [NUM_SECT-1:0] cp_ba,
  input logic [NUM_SECT-1:0] sel_ab,
  input logic [NUM_SECT-1:0] sel_ba,
  input logic [NUM_SECT-1:0] oe_ab,
  input logic [NUM_SECT-1:0] oe_ba_n,
  input logic [BUS_W-1:0]    a_in,
  input logic [BUS_W-1:0]    b_in,
  input logic [BUS_W-1:0]    a_out,
  input logic [BUS_W-1:0]    a_oe,
  input logic [BUS_W-1:0]    b_out,
  input logic [BUS_W-1:0]    b_oe
);

  always_comb begin
    if (rst) p_reset_oe_r1: assert (a_oe == '0 && b_oe == '0);
  end

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_chk
    p_b_enable_r2: assert property (@(posedge clk) disable iff (rst)
      b_oe[s*SECT_W +: SECT_W] == {SECT_W{oe_ab[s]}});

    p_a_enable_r3: assert property (@(posedge clk) disable iff (rst)
      a_oe[s*SECT_W +: SECT_W] == {SECT_W{~oe_ba_n[s]}});

    p_live_ab_r4: assert property (@(posedge clk) disable iff (rst)
      !sel_ab[s] |-> b_out[s*SECT_W +: SECT_W] == a_in[s*SECT_W +: SECT_W]);

    p_live_ba_r5: assert property (@(posedge clk) disable iff (rst)
      !sel_ba[s] |-> a_out[s*SECT_W +: SECT_W] == b_in[s*SECT_W +: SECT_W]);

    // R6: stored output moves only after a sampled strobe rise
    p_hold_ab_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && sel_ab[s] && $past(sel_ab[s]) &&
       !($past(cp_ab[s]) && !$past(cp_ab[s], 2)))
      |-> $stable(b_out[s*SECT_W +: SECT_W]));

    p_hold_ba_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && sel_ba[s] && $past(sel_ba[s]) &&
       !($past(cp_ba[s]) && !$past(cp_ba[s], 2)))
      |-> $stable(a_out[s*SECT_W +: SECT_W]));
  end

endmodule

bind tcvr_dual tcvr_dual_chk #(.SECT_W(SECT_W), .NUM_SECT(NUM_SECT)) i_chk (
  .clk(clk), .rst(rst), .cp_ab(cp_ab), .cp_ba(cp_ba),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe)
);

// File: tb/test_tcvr_dual.sv
`timescale 1ns/1ps
module test_tcvr_dual;

  localparam int SW = 8;
  localparam int NS = 2;
  localparam int BW = SW * NS;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] cp_ab = '0, cp_ba = '0, sel_ab = '0, sel_ba = '0;
  logic [NS-1:0] oe_ab = '1, oe_ba_n = '0;
  logic [BW-1:0] a_in = '0, b_in = '0;
  logic [BW-1:0] a_out, a_oe, b_out, b_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  tcvr_dual #(.SECT_W(SW), .NUM_SECT(NS)) i_tcvr_dual (
    .clk(clk), .rst(rst), .cp_ab(cp_ab), .cp_ba(cp_ba),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  // Strobe high for one sample, then low; returns at a negedge after capture
  task automatic pulse(input logic [NS-1:0] ab, input logic [NS-1:0] ba);
    @(negedge clk); cp_ab = ab; cp_ba = ba;
    @(negedge clk); cp_ab = '0; cp_ba = '0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) step();
    #1;
    chk("R1 a_oe in reset", a_oe, '0);
    chk("R1 b_oe in reset", b_oe, '0);
    step(); rst = 1'b0; sel_ab = '1; sel_ba = '1; #1;
    chk("R1 stored B reg zero", a_out, '0);
    chk("R1 stored A reg zero", b_out, '0);
    chk("R2 b_oe enabled", b_oe, '1);
    chk("R3 a_oe enabled", a_oe, '1);
  endtask

  task automatic t_live;
    logic [BW-1:0] pats [4] = '{16'h1234, 16'hFFFF, 16'h0000, 16'hA55A};
    step(); oe_ab = '1; oe_ba_n = '1; sel_ab = '0; sel_ba = '0;
    foreach (pats[i]) begin
      step(); a_in = pats[i]; #1;
      chk("R4 live A to B", b_out, pats[i]);
      chk("R3 A side released", a_oe, '0);
    end
    step(); oe_ab = '0; oe_ba_n = '0;
    foreach (pats[i]) begin
      step(); b_in = ~pats[i]; #1;
      chk("R5 live B to A", a_out, ~pats[i]);
      chk("R2 B side released", b_oe, '0);
    end
    step(); oe_ab = '1; oe_ba_n = '0; a_in = 16'hC3C3; b_in = 16'h0F0F; #1;
    chk("R8 both live b_out", b_out, 16'hC3C3);
    chk("R8 both live a_out", a_out, 16'h0F0F);
  endtask

  task automatic t_isolate_store;
    step(); oe_ab = '0; oe_ba_n = '1; sel_ab = '1; sel_ba = '1; #1;
    chk("R3 isolation a_oe", a_oe, '0);
    chk("R2 isolation b_oe", b_oe, '0);
    a_in = 16'h3C3C; b_in = 16'hA5A5;
    pulse('1, '1);
    a_in = 16'h0000; b_in = 16'h0000;
    repeat (2) step();
    oe_ab = '1; oe_ba_n = '0; #1;
    chk("R9 stored A on B", b_out, 16'h3C3C);
    chk("R9 stored B on A", a_out, 16'hA5A5);
    // strobe held high loads once only
    step(); oe_ab = '0; oe_ba_n = '1; a_in = 16'h1111; cp_ab = '1;
    step(); a_in = 16'h2222;
    repeat (2) step();
    cp_ab = '0; step(); #1;
    chk("R6 held strobe loads once", b_out, 16'h1111);
  endtask

  task automatic t_copy;
    // B drives live A; B-to-A register samples the driven B pins
    step(); oe_ab = '1; oe_ba_n = '1; sel_ab = '0; sel_ba = '1;
    a_in = 16'h5A5A; b_in = 16'hFFFF;
    pulse('0, '1);
    oe_ab = '0; oe_ba_n = '0; #1;
    chk("R7 copy A into B-to-A reg", a_out, 16'h5A5A);
    // A drives live B; A-to-B register samples the driven A pins
    step(); sel_ba = '0; b_in = 16'h6969; a_in = 16'h0000;
    pulse('1, '0);
    oe_ba_n = '1; oe_ab = '1; sel_ab = '1; #1;
    chk("R7 copy B into A-to-B reg", b_out, 16'h6969);
  endtask

  task automatic t_indep;
    step(); oe_ab = '0; oe_ba_n = '1; sel_ab = '1; a_in = 16'h1111;
    pulse('1, '0);
    a_in = 16'hEE77;
    pulse(2'b01, '0);
    oe_ab = 2'b10; #1;
    chk("R10 only section 0 loaded", b_out, 16'h1177);
    chk("R10 per-section enable", b_oe, 16'hFF00);
    step(); sel_ab = 2'b10; a_in = 16'h4455; #1;
    chk("R10 per-section select", b_out, 16'h1155);
  endtask

  initial begin
    t_reset();
    t_live();
    t_isolate_store();
    t_copy();
    t_indep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule